// File: doc/BRIEF.md
# Exception Pending and Dispatch Unit

This block sits beside a processor pipeline and turns exception requests into control-flow changes in two steps. A request is first written into a pending record: a valid flag, the exception code, the effective address and the live PC of that moment. The record is acted on only at the next fetch boundary, and only while no earlier dispatch is still stalling the core. At that point the live PC jumps to the exception code, which is also the vector address. The next PC becomes that address plus 4. The status-register controls raise supervisor mode and drop the exception-enable bit, and a stall counter freezes the core for a fixed number of cycles.

While an exception is pending, incoming PC updates are not applied. They are parked in a delayed-PC register. At the fetch boundary that register is restored into the live PC. If the restored PC lies outside the memory window, a bus-error exception addressed at that PC replaces the pending one. A debug unit may claim a request as it arrives, which wipes the record. A software clear command removes any pending record except a reset.

Top module: `exc_dispatch_unit`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `pc_o` equals RESET_PC (0), `npc_o` equals RESET_PC+4, `pend_valid_o` is 0, `stall_cnt_o` is 0, `stall_o` is 0, and `sr_sup_set_o` and `sr_exe_clr_o` are 0.
- R2: A request (`exc_req` high with `dbg_claim` low) sets `pend_valid_o` and `pend_type_o` at the next edge. It stores the effective address and the current `pc_o`, and it causes no stall.
- R3: A request that arrives with `dbg_claim` high leaves no pending record, even if one was already held, and it never dispatches.
- R4: A `clr_pend` pulse removes a pending record whose code is not the reset code 0x100. A pending record with code 0x100 stays.
- R5: Dispatch happens only at an edge where `fetch_bnd` is high, `stall_cnt_o` is 0 and a record is pending (or a bus error is raised, R11). The record is cleared by the dispatch.
- R6: On dispatch, `pc_o` becomes the code zero-extended and `npc_o` becomes that value plus 4. `sv_type_o`, `sv_ea_o` and `sv_pc_o` show the dispatched code, the effective address and the saved PC.
- R7: `sr_sup_set_o` and `sr_exe_clr_o` are high for exactly the one cycle that follows a dispatch edge.
- R8: A dispatch loads `stall_cnt_o` with 7. The counter then falls by one per cycle to 0, and `stall_o` is high while it is nonzero. A `fetch_bnd` during that time does nothing.
- R9: A request made during the stall is kept pending and dispatches at the first fetch boundary after the stall ends.
- R10: An `upd_valid` pulse loads `pc_o`/`npc_o` from `upd_pc`/`upd_npc` when nothing is pending. While a record is pending, the pulse leaves `pc_o` unchanged and stores the values in a delayed-PC register, which is restored into the live PC at the next fetch boundary.
- R11: If a restored PC is below MEM_BASE (0x1000) or above MEM_BASE+MEM_LEN (0x9000), a bus error with code 0x200 is dispatched in its place, with effective address and saved PC both equal to that PC. A PC equal to exactly 0x9000 is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req | input | 1 | Exception request strobe |
| exc_type | input | 16 | Exception code, also the vector address |
| exc_ea | input | 32 | Effective address of the faulting access |
| dbg_claim | input | 1 | Debug unit claims the request presented this cycle |
| clr_pend | input | 1 | Drop the pending record unless it is a reset |
| fetch_bnd | input | 1 | Next instruction fetch boundary |
| upd_valid | input | 1 | Pipeline PC update strobe |
| upd_pc | input | 32 | Updated PC |
| upd_npc | input | 32 | Updated next PC |
| pc_o | output | 32 | Live PC |
| npc_o | output | 32 | Live next PC |
| sr_sup_set_o | output | 1 | Set the supervisor bit of the status register |
| sr_exe_clr_o | output | 1 | Clear the exception-enable bit of the status register |
| stall_o | output | 1 | Core stall request |
| stall_cnt_o | output | 3 | Remaining stall cycles |
| pend_valid_o | output | 1 | A record is pending |
| pend_type_o | output | 16 | Code of the pending record |
| sv_type_o | output | 16 | Code of the last dispatched exception |
| sv_ea_o | output | 32 | Effective address of the last dispatched exception |
| sv_pc_o | output | 32 | Saved PC of the last dispatched exception |

## Verification
A vector table raises codes with different effective addresses from different starting PCs. It shows that the vector, next PC and saved bundle follow the code and the capture-time PC, and not a fixed value. Directed sequences then separate the cases where a request is claimed, cleared or protected as a reset. The delayed-PC tests use restored PCs below the window, above it and exactly at its top, which tells a bus error apart from an ordinary vector and an off-by-one range check. Fetch boundaries placed inside the stall, and a request made during it, show that dispatch waits for the counter and that the held record is not lost.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int TYPE_W = 16;

    typedef struct packed {
        logic              valid;
        logic [TYPE_W-1:0] code;
        logic [XLEN-1:0]   ea;
        logic [XLEN-1:0]   saved;
    } pend_rec_t;
endpackage

// File: rtl/exc_pend_rec.sv
module exc_pend_rec
    import exc_pkg::*;
#(
    parameter logic [TYPE_W-1:0] RESET_CODE  = 16'h0100,
    parameter logic [TYPE_W-1:0] BUSERR_CODE = 16'h0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [TYPE_W-1:0] exc_type,
    input  logic [XLEN-1:0]   exc_ea,
    input  logic              dbg_claim,
    input  logic              clr_pend,
    input  logic              fetch_go,
    input  logic              bus_err,
    input  logic [XLEN-1:0]   bus_err_pc,
    input  logic [XLEN-1:0]   live_pc,
    output logic              dispatch,
    output logic [TYPE_W-1:0] vec_code,
    output logic              rec_valid,
    output logic [TYPE_W-1:0] rec_code,
    output logic [TYPE_W-1:0] sv_type,
    output logic [XLEN-1:0]   sv_ea,
    output logic [XLEN-1:0]   sv_pc,
    output logic              disp_pulse
);
    typedef struct packed {
        pend_rec_t         rec;
        pend_rec_t         last;
        logic              pulse;
    } state_t;

    state_t    s_q, s_d;
    pend_rec_t taken;

    always_comb begin
        // bus error raised at restore replaces the pending record
        taken = s_q.rec;
        if (bus_err) begin
            taken.valid = 1'b1;
            taken.code  = BUSERR_CODE;
            taken.ea    = bus_err_pc;
            taken.saved = bus_err_pc;
        end
        dispatch = fetch_go && taken.valid;
        vec_code = taken.code;

        s_d       = s_q;
        s_d.pulse = dispatch;
        if (dispatch) begin
            s_d.last = taken;
            s_d.rec  = '0;
        end else if (clr_pend && s_q.rec.code != RESET_CODE) begin
            s_d.rec = '0;
        end
        if (exc_req) begin
            if (dbg_claim) begin
                s_d.rec = '0;
            end else begin
                s_d.rec.valid = 1'b1;
                s_d.rec.code  = exc_type;
                s_d.rec.ea    = exc_ea;
                s_d.rec.saved = live_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rec_valid  = s_q.rec.valid;
    assign rec_code   = s_q.rec.code;
    assign sv_type    = s_q.last.code;
    assign sv_ea      = s_q.last.ea;
    assign sv_pc      = s_q.last.saved;
    assign disp_pulse = s_q.pulse;

    logic unused_ok;
    assign unused_ok = s_q.last.valid;
endmodule

// File: rtl/exc_pc_hold.sv
module exc_pc_hold
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0,
    parameter logic [XLEN-1:0] MEM_BASE = 32'h0000_1000,
    parameter logic [XLEN-1:0] MEM_LEN  = 32'h0000_8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [XLEN-1:0]   upd_pc,
    input  logic [XLEN-1:0]   upd_npc,
    input  logic              pend_valid,
    input  logic              fetch_go,
    input  logic              dispatch,
    input  logic [TYPE_W-1:0] vec_code,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   npc,
    output logic              bus_err,
    output logic [XLEN-1:0]   bus_err_pc
);
    localparam logic [XLEN-1:0] MEM_TOP = MEM_BASE + MEM_LEN;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] dly_pc;
        logic [XLEN-1:0] dly_npc;
        logic            dly_valid;
    } state_t;

    state_t          s_q, s_d;
    logic [XLEN-1:0] vec_pc;
    logic            out_of_range;

    assign vec_pc       = {{(XLEN-TYPE_W){1'b0}}, vec_code};
    assign out_of_range = (s_q.dly_pc < MEM_BASE) || (s_q.dly_pc > MEM_TOP);
    assign bus_err      = fetch_go && s_q.dly_valid && out_of_range;
    assign bus_err_pc   = s_q.dly_pc;

    always_comb begin
        s_d = s_q;
        if (upd_valid) begin
            if (pend_valid) begin
                s_d.dly_pc    = upd_pc;
                s_d.dly_npc   = upd_npc;
                s_d.dly_valid = 1'b1;
            end else begin
                s_d.pc  = upd_pc;
                s_d.npc = upd_npc;
            end
        end
        if (fetch_go && s_q.dly_valid) begin
            s_d.pc        = s_q.dly_pc;
            s_d.npc       = s_q.dly_npc;
            s_d.dly_valid = 1'b0;
        end
        if (dispatch) begin
            s_d.pc  = vec_pc;
            s_d.npc = vec_pc + 32'd4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q           <= '0;
            s_q.pc        <= RESET_PC;
            s_q.npc       <= RESET_PC + 32'd4;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc  = s_q.pc;
    assign npc = s_q.npc;
endmodule

// File: rtl/exc_stall_ctr.sv
module exc_stall_ctr #(
    parameter int STALL_CYC = 7,
    parameter int CW        = $clog2(STALL_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dispatch,
    output logic          idle,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LOAD = CW'(STALL_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (dispatch)            cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);
    assign cnt  = cnt_q;
endmodule

// File: rtl/exc_dispatch_unit.sv
module exc_dispatch_unit
    import exc_pkg::*;
#(
    parameter int                STALL_CYC   = 7,
    parameter logic [XLEN-1:0]   RESET_PC    = 32'h0,
    parameter logic [XLEN-1:0]   MEM_BASE    = 32'h0000_1000,
    parameter logic [XLEN-1:0]   MEM_LEN     = 32'h0000_8000,
    parameter logic [TYPE_W-1:0] RESET_CODE  = 16'h0100,
    parameter logic [TYPE_W-1:0] BUSERR_CODE = 16'h0200,
    localparam int               CW          = $clog2(STALL_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [TYPE_W-1:0] exc_type,
    input  logic [XLEN-1:0]   exc_ea,
    input  logic              dbg_claim,
    input  logic              clr_pend,
    input  logic              fetch_bnd,
    input  logic              upd_valid,
    input  logic [XLEN-1:0]   upd_pc,
    input  logic [XLEN-1:0]   upd_npc,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   npc_o,
    output logic              sr_sup_set_o,
    output logic              sr_exe_clr_o,
    output logic              stall_o,
    output logic [CW-1:0]     stall_cnt_o,
    output logic              pend_valid_o,
    output logic [TYPE_W-1:0] pend_type_o,
    output logic [TYPE_W-1:0] sv_type_o,
    output logic [XLEN-1:0]   sv_ea_o,
    output logic [XLEN-1:0]   sv_pc_o
);
    logic              idle, fetch_go, dispatch, bus_err, disp_pulse;
    logic [TYPE_W-1:0] vec_code;
    logic [XLEN-1:0]   bus_err_pc;

    assign fetch_go = fetch_bnd && idle;

    exc_pend_rec #(
        .RESET_CODE (RESET_CODE),
        .BUSERR_CODE(BUSERR_CODE)
    ) u_rec (
        .clk        (clk),
        .rst        (rst),
        .exc_req    (exc_req),
        .exc_type   (exc_type),
        .exc_ea     (exc_ea),
        .dbg_claim  (dbg_claim),
        .clr_pend   (clr_pend),
        .fetch_go   (fetch_go),
        .bus_err    (bus_err),
        .bus_err_pc (bus_err_pc),
        .live_pc    (pc_o),
        .dispatch   (dispatch),
        .vec_code   (vec_code),
        .rec_valid  (pend_valid_o),
        .rec_code   (pend_type_o),
        .sv_type    (sv_type_o),
        .sv_ea      (sv_ea_o),
        .sv_pc      (sv_pc_o),
        .disp_pulse (disp_pulse)
    );

    exc_pc_hold #(
        .RESET_PC(RESET_PC),
        .MEM_BASE(MEM_BASE),
        .MEM_LEN (MEM_LEN)
    ) u_pc (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_npc    (upd_npc),
        .pend_valid (pend_valid_o),
        .fetch_go   (fetch_go),
        .dispatch   (dispatch),
        .vec_code   (vec_code),
        .pc         (pc_o),
        .npc        (npc_o),
        .bus_err    (bus_err),
        .bus_err_pc (bus_err_pc)
    );

    exc_stall_ctr #(
        .STALL_CYC(STALL_CYC),
        .CW       (CW)
    ) u_stall (
        .clk      (clk),
        .rst      (rst),
        .dispatch (dispatch),
        .idle     (idle),
        .cnt      (stall_cnt_o)
    );

    assign sr_sup_set_o = disp_pulse;
    assign sr_exe_clr_o = disp_pulse;
    assign stall_o      = !idle;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
    import exc_pkg::*;
#(
    parameter int                STALL_CYC  = 7,
    parameter logic [TYPE_W-1:0] RESET_CODE = 16'h0100,
    parameter int                CW         = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_req,
    input logic              dbg_claim,
    input logic              clr_pend,
    input logic              fetch_bnd,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   npc_o,
    input logic              sr_sup_set_o,
    input logic              sr_exe_clr_o,
    input logic              stall_o,
    input logic [CW-1:0]     stall_cnt_o,
    input logic              pend_valid_o,
    input logic [TYPE_W-1:0] pend_type_o
);
    // R3
    claim_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req && dbg_claim |=> !pend_valid_o);

    // R4
    reset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        clr_pend && !exc_req && !fetch_bnd && pend_valid_o && pend_type_o == RESET_CODE
        |=> pend_valid_o);

    // R5
    fetch_needed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_sup_set_o) |-> $past(fetch_bnd));

    // R6
    next_pc_chk: assert property (@(posedge clk) disable iff (rst)
        sr_sup_set_o |-> npc_o == pc_o + 32'd4);

    // R7
    pulse_pair_chk: assert property (@(posedge clk) disable iff (rst)
        sr_sup_set_o == sr_exe_clr_o);

    // R7
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sr_sup_set_o |=> !sr_sup_set_o);

    // R8
    stall_load_chk: assert property (@(posedge clk) disable iff (rst)
        sr_sup_set_o |-> stall_cnt_o == CW'(STALL_CYC) && stall_o);

    // R8
    stall_step_chk: assert property (@(posedge clk) disable iff (rst)
        stall_cnt_o != '0 |=> stall_cnt_o == $past(stall_cnt_o) - 1'b1);
endmodule

bind exc_dispatch_unit exc_dispatch_chk #(
    .STALL_CYC (STALL_CYC),
    .RESET_CODE(RESET_CODE),
    .CW        (CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exc_req      (exc_req),
    .dbg_claim    (dbg_claim),
    .clr_pend     (clr_pend),
    .fetch_bnd    (fetch_bnd),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .sr_sup_set_o (sr_sup_set_o),
    .sr_exe_clr_o (sr_exe_clr_o),
    .stall_o      (stall_o),
    .stall_cnt_o  (stall_cnt_o),
    .pend_valid_o (pend_valid_o),
    .pend_type_o  (pend_type_o)
);

// File: tb/exc_dispatch_unit_test.sv
module exc_dispatch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 0, dbg_claim = 0, clr_pend = 0, fetch_bnd = 0, upd_valid = 0;
    logic [15:0] exc_type = '0;
    logic [31:0] exc_ea = '0, upd_pc = '0, upd_npc = '0;
    logic [31:0] pc_o, npc_o, sv_ea_o, sv_pc_o;
    logic        sr_sup_set_o, sr_exe_clr_o, stall_o, pend_valid_o;
    logic [2:0]  stall_cnt_o;
    logic [15:0] pend_type_o, sv_type_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    exc_dispatch_unit uut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_type(exc_type), .exc_ea(exc_ea),
        .dbg_claim(dbg_claim), .clr_pend(clr_pend), .fetch_bnd(fetch_bnd),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_npc(upd_npc),
        .pc_o(pc_o), .npc_o(npc_o), .sr_sup_set_o(sr_sup_set_o), .sr_exe_clr_o(sr_exe_clr_o),
        .stall_o(stall_o), .stall_cnt_o(stall_cnt_o), .pend_valid_o(pend_valid_o),
        .pend_type_o(pend_type_o), .sv_type_o(sv_type_o), .sv_ea_o(sv_ea_o), .sv_pc_o(sv_pc_o)
    );

    // {code, effective address, starting pc}
    localparam logic [79:0] VEC [5] = '{
        {16'h0300, 32'hDEAD_0000, 32'h0000_2000},
        {16'h0600, 32'h0000_1234, 32'h0000_4ABC},
        {16'h0C00, 32'hFFFF_FFFC, 32'h0000_8FF0},
        {16'h0100, 32'h0000_0000, 32'h0000_1000},
        {16'h0E04, 32'h5555_AAAA, 32'h0000_9000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_pc(logic [31:0] p);
        upd_valid = 1; upd_pc = p; upd_npc = p + 32'd4;
        cyc();
        upd_valid = 0;
    endtask

    task automatic raise(logic [15:0] t, logic [31:0] ea, logic claim);
        exc_req = 1; exc_type = t; exc_ea = ea; dbg_claim = claim;
        cyc();
        exc_req = 0; dbg_claim = 0;
    endtask

    task automatic fetch();
        fetch_bnd = 1;
        cyc();
        fetch_bnd = 0;
    endtask

    task automatic drain();
        repeat (8) cyc();
    endtask

    task automatic do_reset();
        rst = 1;
        cyc(); cyc();
        rst = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc();
        do_reset();
        // R1 reset state
        chk("R1 pc", pc_o, 32'h0);
        chk("R1 npc", npc_o, 32'h4);
        chk("R1 pend", {31'b0, pend_valid_o}, 32'd0);
        chk("R1 stall", {28'b0, stall_o, stall_cnt_o}, 32'd0);
        chk("R1 sr", {30'b0, sr_sup_set_o, sr_exe_clr_o}, 32'd0);

        // table walk: R2 R6 R7 R8
        for (int i = 0; i < 5; i++) begin
            logic [15:0] t;
            logic [31:0] ea, sp;
            {t, ea, sp} = VEC[i];
            set_pc(sp);
            chk("R10 live update", pc_o, sp);
            raise(t, ea, 1'b0);
            chk("R2 valid", {31'b0, pend_valid_o}, 32'd1);
            chk("R2 code", {16'b0, pend_type_o}, {16'b0, t});
            chk("R2 no stall", {31'b0, stall_o}, 32'd0);
            fetch();
            chk("R6 pc", pc_o, {16'b0, t});
            chk("R6 npc", npc_o, {16'b0, t} + 32'd4);
            chk("R6 sv type", {16'b0, sv_type_o}, {16'b0, t});
            chk("R6 sv ea", sv_ea_o, ea);
            chk("R6 sv pc", sv_pc_o, sp);
            chk("R5 cleared", {31'b0, pend_valid_o}, 32'd0);
            chk("R7 pulse", {30'b0, sr_sup_set_o, sr_exe_clr_o}, 32'd3);
            chk("R8 load", {28'b0, stall_o, stall_cnt_o}, 32'h0F);
            cyc();
            chk("R7 single", {30'b0, sr_sup_set_o, sr_exe_clr_o}, 32'd0);
            chk("R8 step", {29'b0, stall_cnt_o}, 32'd6);
            repeat (6) cyc();
            chk("R8 zero", {28'b0, stall_o, stall_cnt_o}, 32'd0);
        end

        // R3: claim wipes an earlier record as well
        set_pc(32'h2000);
        raise(16'h0300, 32'h1, 1'b0);
        raise(16'h0500, 32'h2, 1'b1);
        chk("R3 wiped", {31'b0, pend_valid_o}, 32'd0);
        fetch();
        chk("R3 no dispatch", pc_o, 32'h2000);
        chk("R3 no stall", {31'b0, stall_o}, 32'd0);

        // R4: clear removes non-reset, keeps reset
        raise(16'h0700, 32'h3, 1'b0);
        clr_pend = 1; cyc(); clr_pend = 0;
        chk("R4 cleared", {31'b0, pend_valid_o}, 32'd0);
        raise(16'h0100, 32'h4, 1'b0);
        clr_pend = 1; cyc(); clr_pend = 0;
        chk("R4 reset kept", {31'b0, pend_valid_o}, 32'd1);
        fetch();
        chk("R4 reset dispatch", pc_o, 32'h0100);
        drain();

        // R8 R9: fetch during stall ignored, request held
        set_pc(32'h3000);
        raise(16'h0300, 32'h5, 1'b0);
        fetch();
        raise(16'h0800, 32'h6, 1'b0);
        fetch();
        chk("R8 fetch in stall", pc_o, 32'h0300);
        chk("R9 held", {16'b0, pend_type_o}, 32'h0800);
        drain();
        chk("R9 still held", {31'b0, pend_valid_o}, 32'd1);
        fetch();
        chk("R9 dispatch", pc_o, 32'h0800);
        chk("R9 saved pc", sv_pc_o, 32'h0300);
        drain();

        // R10: delayed PC restored at fetch once record is cleared
        set_pc(32'h2000);
        raise(16'h0300, 32'h7, 1'b0);
        set_pc(32'h2400);
        chk("R10 live held", pc_o, 32'h2000);
        clr_pend = 1; cyc(); clr_pend = 0;
        fetch();
        chk("R10 restored pc", pc_o, 32'h2400);
        chk("R10 restored npc", npc_o, 32'h2404);
        chk("R10 no stall", {31'b0, stall_o}, 32'd0);

        // R11: below base
        raise(16'h0300, 32'h8, 1'b0);
        set_pc(32'h0800);
        fetch();
        chk("R11 low vec", pc_o, 32'h0200);
        chk("R11 low ea", sv_ea_o, 32'h0800);
        chk("R11 low saved", sv_pc_o, 32'h0800);
        drain();

        // R11: above top
        set_pc(32'h2000);
        raise(16'h0300, 32'h9, 1'b0);
        set_pc(32'h9004);
        fetch();
        chk("R11 high vec", {16'b0, sv_type_o}, 32'h0200);
        chk("R11 high ea", sv_ea_o, 32'h9004);
        drain();

        // R11: exactly at top is in range
        set_pc(32'h2000);
        raise(16'h0300, 32'hA, 1'b0);
        set_pc(32'h9000);
        fetch();
        chk("R11 top ok", pc_o, 32'h0300);
        chk("R11 top saved", sv_pc_o, 32'h2000);
        drain();

        // R1 reset mid-stall
        set_pc(32'h2000);
        raise(16'h0300, 32'hB, 1'b0);
        fetch();
        raise(16'h0400, 32'hC, 1'b0);
        do_reset();
        chk("R1 reset pc", pc_o, 32'h0);
        chk("R1 reset stall", {29'b0, stall_cnt_o}, 32'd0);
        chk("R1 reset pend", {31'b0, pend_valid_o}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule